// File: doc/BRIEF.md
# Serial Notification Frame Decoder

This block turns a one-wire serial notification stream into parallel events. The line rests high. Each frame opens with one low start bit, and every bit lasts two cycles of the sampling clock. A four-bit type code comes next, sent most significant bit first. The decoder reports the type as soon as the type code is complete, and the type decides how long the frame is.

An incoming-power alert (type 0xA) carries nothing after the type code. The line then stays high, and the decoder goes back to hunting for a start bit. A clock-message copy (0xB) and a data-message copy (0xC) each carry 32 more bits, MSB first: an 8-bit channel ID, a 16-bit content word with its high byte first, and an 8-bit timestamp or firmware byte. A decoded message appears on parallel outputs with a one-cycle strobe. Unknown type codes are flagged, and so are low levels where the stream must be high.

Top module: `notif_frame_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released, every strobe output (`type_valid`, `msg_valid`, `type_error`, `frame_error`) is low, and the decoder is hunting for a start bit.
- R2: The input passes through a two-flop synchroniser. A start bit is accepted only when two consecutive synchronised samples are low. A low that lasts a single sample produces no event.
- R3: Each later bit is taken on the second clock of its two-cycle period. The first four bits form the type code, MSB first. For codes 0xA, 0xB and 0xC, `type_valid` pulses and `type_code` shows the code.
- R4: A 0xA frame has no payload. The decoder checks one more bit, which must be high, and then hunts for a start bit again. It never raises `msg_valid` for this frame.
- R5: For 0xB and 0xC frames, the 32 bits after the type code are received MSB first. Bits 31:24 go to `msg_chan`, bits 23:8 to `msg_content` and bits 7:0 to `msg_stamp`. `msg_valid` pulses once after a high stop bit. `msg_is_clock` is 1 for 0xB and 0 for 0xC.
- R6: Any other type code gives a one-cycle `type_error` and no `type_valid`. The decoder then waits for two consecutive high samples before it hunts for a start bit.
- R7: If the bit after the last bit of a frame is low, the decoder gives a one-cycle `frame_error` and no `msg_valid`. It then waits for two high samples before it hunts again.
- R8: Frames sent back to back, with only their one high stop bit between them, are all decoded.
- R9: Every strobe lasts exactly one cycle. `type_code` changes only in a cycle in which `type_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, two cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial notification line, idles high |
| type_valid | output | 1 | One-cycle strobe for a known type code |
| type_code | output | 4 | Last known type code |
| type_error | output | 1 | One-cycle strobe for an unknown type code |
| frame_error | output | 1 | One-cycle strobe for a low stop bit |
| msg_valid | output | 1 | One-cycle strobe for a complete message |
| msg_is_clock | output | 1 | 1 for a clock-message copy, 0 for a data copy |
| msg_chan | output | 8 | Channel ID of the message |
| msg_content | output | 16 | Content word of the message |
| msg_stamp | output | 8 | Timestamp or firmware byte |

## Verification
If the bit counter or the sampling phase goes wrong, the failure shows within the frame it corrupts. The fields come out shifted, or the stop-bit check lands on a payload bit and raises `frame_error` in place of `msg_valid`. If the decoder is stuck in its error-wait or receive state, the strobes for the following frames go missing. Sending frames back to back exposes this within one frame time. Payloads made mostly of zeros and mostly of ones catch bits that are lost or duplicated at byte boundaries.

// File: rtl/notif_frame_decoder.sv
module notif_frame_decoder #(
  parameter int TYPE_W = 4,
  parameter int ID_W = 8,
  parameter int CONT_W = 16,
  parameter int STAMP_W = 8,
  parameter logic [TYPE_W-1:0] CODE_ALERT = 4'hA,
  parameter logic [TYPE_W-1:0] CODE_CLOCK = 4'hB,
  parameter logic [TYPE_W-1:0] CODE_DATA = 4'hC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  output logic               type_valid,
  output logic [TYPE_W-1:0]  type_code,
  output logic               type_error,
  output logic               frame_error,
  output logic               msg_valid,
  output logic               msg_is_clock,
  output logic [ID_W-1:0]    msg_chan,
  output logic [CONT_W-1:0]  msg_content,
  output logic [STAMP_W-1:0] msg_stamp
);
  localparam int PAY_W = ID_W + CONT_W + STAMP_W;
  localparam int TOT_W = TYPE_W + PAY_W;
  localparam int BW = $clog2(TOT_W + 1);
  localparam logic [BW-1:0] LAST_TYPE = BW'(TYPE_W - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(TOT_W - 1);

  typedef enum logic [1:0] {HUNT, RECV, STOP, WAITHI} st_t;

  st_t st;
  logic s1, s2, seen, ph, is_msg, is_clk;
  logic [BW-1:0] bcnt;
  logic [PAY_W-1:0] shreg;
  logic [TYPE_W-1:0] nib;

  assign nib = {shreg[TYPE_W-2:0], s2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      st <= HUNT;
      seen <= 1'b0;
      ph <= 1'b0;
      is_msg <= 1'b0;
      is_clk <= 1'b0;
      bcnt <= '0;
      shreg <= '0;
      type_valid <= 1'b0;
      type_code <= '0;
      type_error <= 1'b0;
      frame_error <= 1'b0;
      msg_valid <= 1'b0;
      msg_is_clock <= 1'b0;
      msg_chan <= '0;
      msg_content <= '0;
      msg_stamp <= '0;
    end else begin
      s1 <= ser_in;
      s2 <= s1;
      type_valid <= 1'b0;
      type_error <= 1'b0;
      frame_error <= 1'b0;
      msg_valid <= 1'b0;
      case (st)
        HUNT: begin
          seen <= !s2 && !seen;
          if (!s2 && seen) begin
            st <= RECV;
            ph <= 1'b0;
            bcnt <= '0;
          end
        end
        RECV: begin
          ph <= !ph;
          if (ph) begin
            shreg <= {shreg[PAY_W-2:0], s2};
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST_TYPE) begin
              if (nib == CODE_ALERT || nib == CODE_CLOCK || nib == CODE_DATA) begin
                type_valid <= 1'b1;
                type_code <= nib;
                is_msg <= (nib != CODE_ALERT);
                is_clk <= (nib == CODE_CLOCK);
                if (nib == CODE_ALERT) st <= STOP;
              end else begin
                type_error <= 1'b1;
                st <= WAITHI;
                seen <= 1'b0;
              end
            end else if (bcnt == LAST_BIT) begin
              st <= STOP;
            end
          end
        end
        STOP: begin
          ph <= !ph;
          if (ph) begin
            seen <= 1'b0;
            if (s2) begin
              st <= HUNT;
              if (is_msg) begin
                msg_valid <= 1'b1;
                msg_is_clock <= is_clk;
                msg_chan <= shreg[PAY_W-1 -: ID_W];
                msg_content <= shreg[STAMP_W +: CONT_W];
                msg_stamp <= shreg[STAMP_W-1:0];
              end
            end else begin
              frame_error <= 1'b1;
              st <= WAITHI;
            end
          end
        end
        default: begin
          seen <= s2;
          if (s2 && seen) begin
            st <= HUNT;
            seen <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

module notif_frame_decoder_chk #(
  parameter int TYPE_W = 4,
  parameter logic [TYPE_W-1:0] CODE_ALERT = 4'hA,
  parameter logic [TYPE_W-1:0] CODE_CLOCK = 4'hB,
  parameter logic [TYPE_W-1:0] CODE_DATA = 4'hC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              type_valid,
  input logic [TYPE_W-1:0] type_code,
  input logic              type_error,
  input logic              frame_error,
  input logic              msg_valid,
  input logic              msg_is_clock
);
  AST_TV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) type_valid |=> !type_valid); // R9
  AST_MV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) msg_valid |=> !msg_valid); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({type_valid, type_error, frame_error, msg_valid}) <= 1); // R7
  AST_TV_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    type_valid |-> (type_code == CODE_ALERT || type_code == CODE_CLOCK || type_code == CODE_DATA)); // R3
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(type_code) |-> type_valid); // R9
  AST_MSG_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (type_code != CODE_ALERT && msg_is_clock == (type_code == CODE_CLOCK))); // R5
endmodule

bind notif_frame_decoder notif_frame_decoder_chk #(
  .TYPE_W(TYPE_W), .CODE_ALERT(CODE_ALERT), .CODE_CLOCK(CODE_CLOCK), .CODE_DATA(CODE_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .type_valid(type_valid), .type_code(type_code),
  .type_error(type_error), .frame_error(frame_error), .msg_valid(msg_valid),
  .msg_is_clock(msg_is_clock)
);

// File: tb/sim_notif_frame_decoder.sv
module sim_notif_frame_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b1;
  logic type_valid, type_error, frame_error, msg_valid, msg_is_clock;
  logic [3:0] type_code;
  logic [7:0] msg_chan, msg_stamp;
  logic [15:0] msg_content;

  notif_frame_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .type_valid(type_valid),
    .type_code(type_code), .type_error(type_error), .frame_error(frame_error),
    .msg_valid(msg_valid), .msg_is_clock(msg_is_clock), .msg_chan(msg_chan),
    .msg_content(msg_content), .msg_stamp(msg_stamp)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int tv_exp = 0, mv_exp = 0, te_exp = 0, fe_exp = 0;
  int tv_seen = 0, mv_seen = 0, te_seen = 0, fe_seen = 0;
  logic [3:0] exp_type [0:127];
  logic [31:0] exp_pay [0:127];
  bit exp_clk [0:127];
  bit prev_tv = 0, prev_mv = 0, done = 0;

  // {type, payload, stop bit}
  localparam logic [36:0] VEC [9] = '{
    {4'hA, 32'h0000_0000, 1'b1},
    {4'hB, 32'h1234_5678, 1'b1},
    {4'hC, 32'h9ABC_DEF0, 1'b1},
    {4'hC, 32'h0000_0000, 1'b1},
    {4'hB, 32'hFFFF_FFFF, 1'b1},
    {4'h5, 32'h0000_0000, 1'b1},
    {4'hF, 32'h0000_0000, 1'b1},
    {4'hC, 32'h0FF0_0FA5, 1'b0},
    {4'hA, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (type_valid) begin
        chk(!prev_tv, "R9 type_valid width", 64'(prev_tv), 0);
        chk(tv_seen < tv_exp && type_code == exp_type[tv_seen[6:0]], "R3 type_code",
            64'(type_code), 64'(exp_type[tv_seen[6:0]]));
        tv_seen++;
      end
      if (msg_valid) begin
        chk(!prev_mv, "R9 msg_valid width", 64'(prev_mv), 0);
        chk(mv_seen < mv_exp && {msg_chan, msg_content, msg_stamp} == exp_pay[mv_seen[6:0]],
            "R5 fields", 64'({msg_chan, msg_content, msg_stamp}), 64'(exp_pay[mv_seen[6:0]]));
        chk(msg_is_clock == exp_clk[mv_seen[6:0]], "R5 clock flag",
            64'(msg_is_clock), 64'(exp_clk[mv_seen[6:0]]));
        mv_seen++;
      end
      if (type_error) te_seen++;
      if (frame_error) fe_seen++;
      prev_tv = type_valid;
      prev_mv = msg_valid;
    end
  end

  task automatic send_bit(input bit b);
    ser_in = b;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [3:0] t, input logic [31:0] p, input bit stopb);
    bit known = (t == 4'hA || t == 4'hB || t == 4'hC);
    bit msg = (t == 4'hB || t == 4'hC);
    if (known) begin
      exp_type[tv_exp[6:0]] = t;
      tv_exp++;
      if (!stopb) fe_exp++;
      else if (msg) begin
        exp_pay[mv_exp[6:0]] = p;
        exp_clk[mv_exp[6:0]] = (t == 4'hB);
        mv_exp++;
      end
    end else te_exp++;
    send_bit(1'b0);
    for (int i = 3; i >= 0; i--) send_bit(t[i]);
    if (msg) for (int i = 31; i >= 0; i--) send_bit(p[i]);
    if (known) send_bit(stopb);
  endtask

  task automatic counts(input string tag);
    chk(tv_seen == tv_exp, {tag, " type_valid count"}, 64'(tv_seen), 64'(tv_exp));
    chk(mv_seen == mv_exp, {tag, " msg_valid count"}, 64'(mv_seen), 64'(mv_exp));
    chk(te_seen == te_exp, {tag, " type_error count"}, 64'(te_seen), 64'(te_exp));
    chk(fe_seen == fe_exp, {tag, " frame_error count"}, 64'(fe_seen), 64'(fe_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1: strobes quiet in reset
    chk({type_valid, msg_valid, type_error, frame_error} == 0, "R1 in reset",
        64'({type_valid, msg_valid, type_error, frame_error}), 0);
    rst_n = 1'b1;
    repeat (4) send_bit(1'b1);
    chk({type_valid, msg_valid, type_error, frame_error} == 0, "R1 after reset",
        64'({type_valid, msg_valid, type_error, frame_error}), 0);
    counts("R1");

    // R3 R4 R5 R6 R7: table walk
    for (int k = 0; k < 9; k++) begin
      frame(VEC[k][36:33], VEC[k][32:1], VEC[k][0]);
      repeat (3) send_bit(1'b1);
    end
    counts("R3 R4 R5 R6 R7");

    // R2: single-sample low is ignored
    ser_in = 1'b0;
    @(negedge clk);
    ser_in = 1'b1;
    repeat (6) send_bit(1'b1);
    counts("R2 glitch");

    // R6: after an unknown code, a good frame decodes
    frame(4'h0, 32'h0, 1'b1);
    send_bit(1'b1);
    frame(4'hB, 32'hA55A_3CC3, 1'b1);
    repeat (3) send_bit(1'b1);
    counts("R6 recovery");

    // R8: back-to-back frames, gap is only the stop bit
    for (int k = 0; k < 20; k++) begin
      int r = int'($urandom_range(0, 2));
      frame(r == 0 ? 4'hA : (r == 1 ? 4'hB : 4'hC), $urandom, 1'b1);
    end
    repeat (3) send_bit(1'b1);
    counts("R8");

    // R1: reset in mid-frame, then a clean frame
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    rst_n = 1'b0;
    ser_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) send_bit(1'b1);
    counts("R1 mid-frame reset");
    frame(4'hC, 32'h0102_0304, 1'b1);
    repeat (3) send_bit(1'b1);
    counts("R1 post-reset frame");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule